// File: doc/BRIEF.md
# Multi-cycle accumulator processor core

This block is a small accumulator machine. A state-machine control unit steps each instruction through a fetch, a decode and an execute phase. Every phase is an explicit register transfer through a program counter, a memory address register, a memory data register, an instruction register and a 16-bit accumulator. Program and data share one internal memory of 256 words of 16 bits. That memory reads synchronously, with one cycle of latency, so the control unit inserts one wait state between loading the address register and latching the data register.

An instruction word is 16 bits. The high byte selects the operation and the low byte gives a memory address. While reset is held, a test port fills the memory one word per cycle. When reset is released, execution starts at address 0. The same port can read any word back at any time. Data words are normally placed after the last instruction of the program. An opcode outside the defined set stops the core, which then raises `halted` until the next reset.

Top module: `acc_cpu`

## Requirements
- R1: Bits 15:8 of an instruction word are the opcode and bits 7:0 are the operand address. Opcode 0x00 adds the addressed word to the accumulator, 0x01 writes the accumulator to the addressed word, and 0x02 loads the addressed word into the accumulator.
- R2: A synchronous reset clears the PC, accumulator, IR, MAR and MDR, returns control to the fetch state and drops `halted`. Memory contents survive reset. Execution begins at address 0.
- R3: A fetch takes four cycles: the PC goes to the MAR, one wait state passes, the read word goes to the MDR, and then the MDR goes to the IR while the PC increments modulo 256. A decode cycle follows, so `dbg_pc` shows the incremented value after the 4th edge of every instruction.
- R4: LOAD and ADD take 8 cycles in total, and `dbg_acc` takes its new value after the 8th edge. ADD wraps modulo 2^16.
- R5: STORE takes 6 cycles. The memory word changes at the 6th edge and can be read on `tp_rdata` after that edge.
- R6: Opcode 0x03 (jump) loads the PC with the operand address at the 5th edge, and the instruction takes 5 cycles.
- R7: Opcode 0x04 (jump if negative) takes 5 cycles. It loads the operand address into the PC only when accumulator bit 15 is 1; otherwise the incremented PC stands.
- R8: Any opcode above 0x04 halts the core after the 5th edge. `halted` then stays 1 and both `dbg_pc` and `dbg_acc` stay constant until reset.
- R9: `tp_rdata` shows the word at `tp_addr` as of the last edge. A word on `tp_we` is written at the next edge. If a test-port write and a STORE happen in the same cycle, only the test-port word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tp_we | input | 1 | Test-port write strobe |
| tp_addr | input | 8 | Test-port word address |
| tp_wdata | input | 16 | Test-port write word |
| tp_rdata | output | 16 | Memory word at tp_addr |
| halted | output | 1 | Core stopped on an undefined opcode |
| dbg_pc | output | 8 | Program counter |
| dbg_acc | output | 16 | Accumulator |

## Verification
The two functions that can fall in the same cycle are a core STORE and a test-port write to the same memory word. The bench provokes the collision by timing a test-port write, carrying a marker value, to land in the write cycle of one chosen STORE inside a counting loop. It judges the result by comparing `tp_rdata` against its model on every cycle. The model expects the marker to win in that cycle and the next STORE to overwrite it.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    typedef enum logic [3:0] {
        ST_FETCH  = 4'd0,
        ST_FWAIT  = 4'd1,
        ST_FMDR   = 4'd2,
        ST_FIR    = 4'd3,
        ST_DECODE = 4'd4,
        ST_XWAIT  = 4'd5,
        ST_XMDR   = 4'd6,
        ST_XEXEC  = 4'd7,
        ST_XSTORE = 4'd8,
        ST_HALT   = 4'd9
    } cpu_state_e;

    typedef enum logic {
        ALU_PASS = 1'b0,
        ALU_ADD  = 1'b1
    } alu_op_e;

    localparam logic [7:0] OPC_ADD   = 8'h00;
    localparam logic [7:0] OPC_STORE = 8'h01;
    localparam logic [7:0] OPC_LOAD  = 8'h02;
    localparam logic [7:0] OPC_JUMP  = 8'h03;
    localparam logic [7:0] OPC_JNEG  = 8'h04;

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] cpu_raddr,
    output logic [DW-1:0] cpu_rdata,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_waddr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          tp_we,
    input  logic [AW-1:0] tp_addr,
    input  logic [DW-1:0] tp_wdata,
    output logic [DW-1:0] tp_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_q;

    // Test port has priority over the core on a same-cycle write.
    always_ff @(posedge clk) begin
        if (tp_we) begin
            mem_q[tp_addr] <= tp_wdata;
        end else if (cpu_we) begin
            mem_q[cpu_waddr] <= cpu_wdata;
        end
        rdata_q <= mem_q[cpu_raddr];
    end

    assign cpu_rdata = rdata_q;
    assign tp_rdata  = mem_q[tp_addr];

    // R9: a test-port word always lands, whatever the core does
    a_r9_tp_write_wins: assert property (@(posedge clk) disable iff (rst)
        tp_we |=> mem_q[$past(tp_addr)] == $past(tp_wdata));

    // R5: a core store lands when the test port is idle
    a_r5_store_lands: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && !tp_we) |=> mem_q[$past(cpu_waddr)] == $past(cpu_wdata));

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DW = 16
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] operand,
    output logic [DW-1:0] result
);
    always_comb begin
        case (op)
            ALU_ADD: result = acc + operand;
            default: result = operand;
        endcase
    end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_raddr,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata,
    output alu_op_e       alu_op,
    output logic [DW-1:0] alu_acc,
    output logic [DW-1:0] alu_operand,
    input  logic [DW-1:0] alu_result,
    output logic          halted,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] acc
);
    typedef struct packed {
        cpu_state_e    st;
        logic [AW-1:0] pc;
        logic [AW-1:0] mar;
        logic [DW-1:0] mdr;
        logic [DW-1:0] ir;
        logic [DW-1:0] acc;
    } regs_t;

    regs_t         r_q, r_d;
    logic [7:0]    opc;
    logic [AW-1:0] opnd;

    assign opc  = 8'(r_q.ir[DW-1:AW]);
    assign opnd = r_q.ir[AW-1:0];

    always_comb begin
        r_d    = r_q;
        mem_we = 1'b0;
        alu_op = ALU_PASS;
        case (r_q.st)
            ST_FETCH: begin
                r_d.mar = r_q.pc;
                r_d.st  = ST_FWAIT;
            end
            ST_FWAIT: r_d.st = ST_FMDR;
            ST_FMDR: begin
                r_d.mdr = mem_rdata;
                r_d.st  = ST_FIR;
            end
            ST_FIR: begin
                r_d.ir = r_q.mdr;
                r_d.pc = r_q.pc + 1'b1;
                r_d.st = ST_DECODE;
            end
            ST_DECODE: begin
                case (opc)
                    OPC_ADD, OPC_LOAD: begin
                        r_d.mar = opnd;
                        r_d.st  = ST_XWAIT;
                    end
                    OPC_STORE: begin
                        r_d.mar = opnd;
                        r_d.mdr = r_q.acc;
                        r_d.st  = ST_XSTORE;
                    end
                    OPC_JUMP: begin
                        r_d.pc = opnd;
                        r_d.st = ST_FETCH;
                    end
                    OPC_JNEG: begin
                        if (r_q.acc[DW-1]) begin
                            r_d.pc = opnd;
                        end
                        r_d.st = ST_FETCH;
                    end
                    default: r_d.st = ST_HALT;
                endcase
            end
            ST_XWAIT: r_d.st = ST_XMDR;
            ST_XMDR: begin
                r_d.mdr = mem_rdata;
                r_d.st  = ST_XEXEC;
            end
            ST_XEXEC: begin
                alu_op  = (opc == OPC_ADD) ? ALU_ADD : ALU_PASS;
                r_d.acc = alu_result;
                r_d.st  = ST_FETCH;
            end
            ST_XSTORE: begin
                mem_we = 1'b1;
                r_d.st = ST_FETCH;
            end
            ST_HALT: r_d.st = ST_HALT;
            default: r_d.st = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q    <= '0;
            r_q.st <= ST_FETCH;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_raddr   = r_q.mar;
    assign mem_waddr   = r_q.mar;
    assign mem_wdata   = r_q.mdr;
    assign alu_acc     = r_q.acc;
    assign alu_operand = r_q.mdr;
    assign halted      = (r_q.st == ST_HALT);
    assign pc          = r_q.pc;
    assign acc         = r_q.acc;

    // R3: the fetch hands the PC to the MAR and then waits one cycle
    a_r3_fetch_wait: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_FETCH) |=> (r_q.st == ST_FWAIT) && (r_q.mar == $past(r_q.pc)));

    // R3: the IR load steps the PC by one
    a_r3_pc_step: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_FIR) |=> r_q.pc == AW'($past(r_q.pc) + 1'b1));

    // R6: a decoded jump leaves the operand address in the PC
    a_r6_jump_target: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_DECODE && opc == OPC_JUMP) |=> r_q.pc == $past(opnd));

    // R8: the halted state is held with frozen PC and accumulator
    a_r8_halt_hold: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted && $stable(r_q.pc) && $stable(r_q.acc));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tp_we,
    input  logic [AW-1:0] tp_addr,
    input  logic [DW-1:0] tp_wdata,
    output logic [DW-1:0] tp_rdata,
    output logic          halted,
    output logic [AW-1:0] dbg_pc,
    output logic [DW-1:0] dbg_acc
);
    logic [AW-1:0] mem_raddr, mem_waddr;
    logic [DW-1:0] mem_rdata, mem_wdata;
    logic          mem_we;
    alu_op_e       alu_op;
    logic [DW-1:0] alu_acc, alu_operand, alu_result;

    acc_cpu_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .mem_rdata   (mem_rdata),
        .mem_raddr   (mem_raddr),
        .mem_we      (mem_we),
        .mem_waddr   (mem_waddr),
        .mem_wdata   (mem_wdata),
        .alu_op      (alu_op),
        .alu_acc     (alu_acc),
        .alu_operand (alu_operand),
        .alu_result  (alu_result),
        .halted      (halted),
        .pc          (dbg_pc),
        .acc         (dbg_acc)
    );

    acc_cpu_alu #(.DW(DW)) u_alu (
        .op      (alu_op),
        .acc     (alu_acc),
        .operand (alu_operand),
        .result  (alu_result)
    );

    acc_cpu_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk       (clk),
        .rst       (rst),
        .cpu_raddr (mem_raddr),
        .cpu_rdata (mem_rdata),
        .cpu_we    (mem_we),
        .cpu_waddr (mem_waddr),
        .cpu_wdata (mem_wdata),
        .tp_we     (tp_we),
        .tp_addr   (tp_addr),
        .tp_wdata  (tp_wdata),
        .tp_rdata  (tp_rdata)
    );
endmodule

// File: tb/acc_cpu_bench.sv
`timescale 1ns/1ps
module acc_cpu_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tp_we = 1'b0;
    logic [7:0]  tp_addr = 8'h00;
    logic [15:0] tp_wdata = 16'h0000;
    logic [15:0] tp_rdata;
    logic        halted;
    logic [7:0]  dbg_pc;
    logic [15:0] dbg_acc;

    int checks = 0;
    int errors = 0;

    logic [15:0] mem_m [256];
    logic [7:0]  pc_m;
    logic [15:0] acc_m;
    logic        halt_m;

    always #2.5 clk = ~clk;

    acc_cpu u_acc_cpu (
        .clk(clk), .rst(rst), .tp_we(tp_we), .tp_addr(tp_addr),
        .tp_wdata(tp_wdata), .tp_rdata(tp_rdata), .halted(halted),
        .dbg_pc(dbg_pc), .dbg_acc(dbg_acc)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cmp_all(input string req);
        chk(req, "pc", {24'h0, dbg_pc}, {24'h0, pc_m});
        chk(req, "acc", {16'h0, dbg_acc}, {16'h0, acc_m});
        chk(req, "halted", {31'h0, halted}, {31'h0, halt_m});
        chk(req, "tp_rdata", {16'h0, tp_rdata}, {16'h0, mem_m[tp_addr]});
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem_m[i] = 16'h0000;
    endtask

    // Enter reset, check the cleared state (R2), then load memory through the test port.
    task automatic reset_and_load();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R2", "reset pc", {24'h0, dbg_pc}, 32'h0);
        chk("R2", "reset acc", {16'h0, dbg_acc}, 32'h0);
        chk("R2", "reset halted", {31'h0, halted}, 32'h0);
        for (int i = 0; i < 256; i++) begin
            tp_we    = 1'b1;
            tp_addr  = 8'(i);
            tp_wdata = mem_m[i];
            @(posedge clk);
            @(negedge clk);
        end
        tp_we = 1'b0;
    endtask

    // Per-instruction cycle model: fetch 4 edges, decode on edge 5,
    // store on edge 6, load/add result on edge 8.
    task automatic run_prog(input int max_cycles, input int coll_store,
                            input logic [15:0] coll_val, input logic [7:0] watch);
        int stores = 0;
        int cycles = 0;
        logic [15:0] instr;
        logic [7:0]  op, a;
        int n;
        string tag;
        pc_m = 8'h00; acc_m = 16'h0000; halt_m = 1'b0;
        tp_addr = watch;
        rst = 1'b0;
        while (!halt_m && cycles < max_cycles) begin
            instr = mem_m[pc_m];
            op = instr[15:8];
            a  = instr[7:0];
            n  = (op == 8'h00 || op == 8'h02) ? 8 : (op == 8'h01) ? 6 : 5;
            case (op)
                8'h00, 8'h02: tag = "R4";
                8'h01:        tag = "R5";
                8'h03:        tag = "R6";
                8'h04:        tag = "R7";
                default:      tag = "R8";
            endcase
            for (int k = 1; k <= n; k++) begin
                if (op == 8'h01 && k == 6) tp_addr = a;
                if (op == 8'h01 && k == 6 && stores == coll_store) begin
                    tp_we    = 1'b1;
                    tp_wdata = coll_val;
                end
                @(posedge clk);
                if (k == 4) pc_m = pc_m + 8'd1;
                if (k == 5) begin
                    if (op == 8'h03) pc_m = a;
                    if (op == 8'h04 && acc_m[15]) pc_m = a;
                    if (op > 8'h04) halt_m = 1'b1;
                end
                if (k == 6 && op == 8'h01) begin
                    mem_m[a] = tp_we ? coll_val : acc_m;
                    stores++;
                end
                if (k == 8) acc_m = (op == 8'h02) ? mem_m[a] : acc_m + mem_m[a];
                @(negedge clk);
                if (tp_we) begin
                    tp_we = 1'b0;
                    cmp_all("R9");
                end else if (k <= 4) begin
                    cmp_all("R3");
                end else begin
                    cmp_all(tag);
                end
                tp_addr = watch;
            end
            cycles += n;
        end
        chk("R8", "program halted", {31'h0, halt_m}, 32'h1);
        for (int j = 0; j < 8; j++) begin
            @(posedge clk);
            @(negedge clk);
            cmp_all("R8");
        end
    endtask

    task automatic read_word(input string req, input logic [7:0] addr,
                             input logic [15:0] exp);
        tp_addr = addr;
        #1;
        chk(req, "memory word", {16'h0, tp_rdata}, {16'h0, exp});
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL R2 watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Program 1: load, add, store, halt (R1, R4, R5)
        clear_mem();
        mem_m[0] = 16'h0210; mem_m[1] = 16'h0011;
        mem_m[2] = 16'h0112; mem_m[3] = 16'hFF00;
        mem_m[8'h10] = 16'd5; mem_m[8'h11] = 16'd7;
        reset_and_load();
        run_prog(200, -1, 16'h0, 8'h12);
        read_word("R1", 8'h12, 16'd12);
        chk("R4", "final acc", {16'h0, dbg_acc}, 32'd12);

        // Program 2: wrap to negative, taken and untaken branch, jump, opcode 0x05
        clear_mem();
        mem_m[0]  = 16'h0230; mem_m[1]  = 16'h0031; mem_m[2]  = 16'h0405;
        mem_m[3]  = 16'h0120; mem_m[4]  = 16'hFF00; mem_m[5]  = 16'h0121;
        mem_m[6]  = 16'h0308; mem_m[7]  = 16'hFF00; mem_m[8]  = 16'h0232;
        mem_m[9]  = 16'h0400; mem_m[10] = 16'h0122; mem_m[11] = 16'h0500;
        mem_m[8'h30] = 16'h7FFF; mem_m[8'h31] = 16'h0001; mem_m[8'h32] = 16'h0003;
        reset_and_load();
        run_prog(400, -1, 16'h0, 8'h21);
        read_word("R4", 8'h21, 16'h8000);
        read_word("R7", 8'h20, 16'h0000);
        read_word("R7", 8'h22, 16'h0003);
        chk("R8", "halt pc", {24'h0, dbg_pc}, 32'd12);

        // Program 3: counting loop, collision on the second store (R9)
        clear_mem();
        mem_m[0] = 16'h0240; mem_m[1] = 16'h0041; mem_m[2] = 16'h0142;
        mem_m[3] = 16'h0401; mem_m[4] = 16'hFF00;
        mem_m[8'h40] = 16'hFFFD; mem_m[8'h41] = 16'h0001;
        reset_and_load();
        run_prog(600, 1, 16'hBEEF, 8'h42);
        read_word("R9", 8'h42, 16'h0000);
        chk("R7", "loop acc", {16'h0, dbg_acc}, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule